// File: doc/BRIEF.md
# Exception Frame Sequencer

This block carries a 32-bit core into an exception handler and back out again. To start an entry, the core pulses a start line and presents the exception number, the resume PC, the current 16-bit status word, the active stack pointer and the vector table base. The sequencer then aligns the stack. It pushes a two-word frame through a 32-bit memory port: the resume address, and a format word that records the vector offset, the old status word and the two stack bits that were discarded by the alignment. It raises privilege, asks the core to switch stacks, and fetches the handler address from the vector table.

To return, the core pulses a second start line with the current stack pointer. The sequencer pops the format word and the PC. It restores the status word, puts the saved misalignment back into the stack pointer and drops the frame. A hardware interrupt request is taken only if its level is above the current mask.

Top module: `exc_frame_seq`

## Requirements
- R1: The format word pushed on entry is 0x4 in bits 31:28, with the incoming stack pointer's bits 1:0 ORed into bits 29:28. Bits 25:16 hold the vector offset (vector number times 4) and bits 15:0 hold the status word as it was before entry.
- R2: On entry the stack pointer is first rounded down to a multiple of 4; call this A. The resume address is written at A-4 and the format word at A-8. After the handler fetch, sp_out equals A-8.
- R3: After both writes, the handler address is read at vbr_in plus the vector offset. That word appears on pc_out.
- R4: Entry sets the supervisor bit (bit 13) of the status word. A hardware entry also writes the interrupt level into the mask field (bits 10:8) and clears bit 12. A software entry changes no other bit.
- R5: For software exceptions 32 through 47 (the trap range), the resume address written to the stack is pc_in+2. For every other software exception and for all hardware interrupts, it is pc_in.
- R6: On return the format word is read at sp_in and the PC at sp_in+4. sr_out takes the format word's bits 15:0, pc_out takes the second word, and sp_out becomes (sp_in OR format bits 29:28) + 8.
- R7: A hardware request is taken only when the current mask (sr_in bits 10:8) is strictly less than irq_level. A request that fails this test is ignored: busy stays low and no memory access is made. The vector used is irq_vec as sampled on the accepting edge.
- R8: sp_switch pulses for one cycle once per entry and once per return. It comes only after sr_out already shows the new status word.
- R9: Each memory access holds mem_valid, mem_addr, mem_we and mem_wdata until mem_ready is seen. An entry makes exactly three transfers and a return makes exactly two.
- R10: busy is high from the cycle after the start pulse until done, and it is low in the cycle done is high. done lasts exactly one cycle.
- R11: After reset the sequencer is idle, with busy, done, sp_switch and mem_valid all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_exc | input | 1 | Start a software exception entry |
| start_irq | input | 1 | Request a hardware interrupt entry |
| start_ret | input | 1 | Start a return from exception |
| exc_idx | input | VW | Software exception number |
| irq_level | input | 3 | Pending interrupt level |
| irq_vec | input | VW | Vector number for the pending interrupt |
| pc_in | input | AW | PC of the faulting or interrupted instruction |
| sr_in | input | 16 | Current status word |
| sp_in | input | AW | Active stack pointer |
| vbr_in | input | AW | Vector table base address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | AW | New PC (handler or resume address) |
| sr_out | output | 16 | New status word |
| sp_out | output | AW | New stack pointer |
| sp_switch | output | 1 | Request to switch the stack bank |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_rdata | input | 32 | Memory read data |

## Verification
The hardest case to reach is a return that has to rebuild a misaligned stack pointer from a frame pushed by a real entry. The bench handles this by following every random entry with a return that starts from the sp_out the entry produced. It then checks that the original unaligned pointer, the status word and the resume address all come back exactly. A ready line that stalls at random stretches every access, which exercises the hold behaviour. Interrupt requests at a level equal to the mask sit right at the edge of acceptance and must leave the port silent.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int SR_SUP_BIT  = 13;
  localparam int SR_MSTR_BIT = 12;
  localparam int SR_MASK_LSB = 8;
  localparam int SR_MASK_W   = 3;
  localparam logic [3:0] FMT_TAG = 4'h4;

  typedef enum logic [2:0] {
    S_IDLE, S_SWITCH, S_PUSH_PC, S_PUSH_FMT, S_VEC, S_POP_FMT, S_POP_PC
  } seq_st_t;
endpackage

// File: rtl/exc_frame_build.sv
module exc_frame_build
  import exc_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_COUNT = 16
) (
  input  logic [VW-1:0]        idx,
  input  logic                 is_hw,
  input  logic [SR_MASK_W-1:0] level,
  input  logic [AW-1:0]        pc,
  input  logic [15:0]          sr,
  input  logic [AW-1:0]        sp,
  output logic [31:0]          fmt,
  output logic [15:0]          sr_new,
  output logic [AW-1:0]        ret_pc,
  output logic [AW-1:0]        sp_base
);
  localparam int OFFW = VW + 2;
  localparam logic [VW-1:0] TRAP_LO = VW'(TRAP_BASE);
  localparam logic [VW-1:0] TRAP_HI = VW'(TRAP_BASE + TRAP_COUNT - 1);

  logic [OFFW-1:0] off;
  logic            is_trap;

  assign off     = {idx, 2'b00};
  assign is_trap = !is_hw && (idx >= TRAP_LO) && (idx <= TRAP_HI);
  assign ret_pc  = pc + (is_trap ? AW'(2) : AW'(0));
  assign sp_base = {sp[AW-1:2], 2'b00};

  always_comb begin
    fmt = '0;
    fmt[31:28] = FMT_TAG;
    fmt[29:28] = fmt[29:28] | sp[1:0];
    fmt[16 +: OFFW] = off;
    fmt[15:0] = sr;
    sr_new = sr;
    sr_new[SR_SUP_BIT] = 1'b1;
    if (is_hw) begin
      sr_new[SR_MASK_LSB +: SR_MASK_W] = level;
      sr_new[SR_MSTR_BIT] = 1'b0;
    end
  end
endmodule

// File: rtl/exc_frame_restore.sv
module exc_frame_restore #(
  parameter int AW = 32
) (
  input  logic [31:0]   fmt,
  input  logic [AW-1:0] sp,
  output logic [15:0]   sr_rest,
  output logic [AW-1:0] sp_rest
);
  assign sr_rest = fmt[15:0];
  assign sp_rest = (sp | AW'(fmt[29:28])) + AW'(8);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import exc_seq_pkg::*;
(
  input  logic                 req,
  input  logic [15:0]          sr,
  input  logic [SR_MASK_W-1:0] level,
  output logic                 take
);
  assign take = req && (sr[SR_MASK_LSB +: SR_MASK_W] < level);
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_COUNT = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_exc,
  input  logic          start_irq,
  input  logic          start_ret,
  input  logic [VW-1:0] exc_idx,
  input  logic [2:0]    irq_level,
  input  logic [VW-1:0] irq_vec,
  input  logic [AW-1:0] pc_in,
  input  logic [15:0]   sr_in,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] vbr_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [15:0]   sr_out,
  output logic [AW-1:0] sp_out,
  output logic          sp_switch,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata
);
  seq_st_t       st;
  logic [VW-1:0] idx_q;
  logic [31:0]   fmt_q;
  logic [AW-1:0] retpc_q, spb_q, vbr_q;

  logic          irq_take, go_exc, go_irq, go_ret, xfer;
  logic [VW-1:0] idx_sel;
  logic [31:0]   b_fmt;
  logic [15:0]   b_sr, r_sr;
  logic [AW-1:0] b_ret, b_spb, r_sp;

  irq_gate u_gate (.req(start_irq), .sr(sr_in), .level(irq_level), .take(irq_take));

  assign go_exc  = (st == S_IDLE) && start_exc;
  assign go_irq  = (st == S_IDLE) && !start_exc && irq_take;
  assign go_ret  = (st == S_IDLE) && !start_exc && !start_irq && start_ret;
  assign idx_sel = start_exc ? exc_idx : irq_vec;

  exc_frame_build #(.AW(AW), .VW(VW), .TRAP_BASE(TRAP_BASE), .TRAP_COUNT(TRAP_COUNT)) u_build (
    .idx(idx_sel), .is_hw(!start_exc), .level(irq_level), .pc(pc_in), .sr(sr_in),
    .sp(sp_in), .fmt(b_fmt), .sr_new(b_sr), .ret_pc(b_ret), .sp_base(b_spb)
  );

  exc_frame_restore #(.AW(AW)) u_rest (
    .fmt(fmt_q), .sp(spb_q), .sr_rest(r_sr), .sp_rest(r_sp)
  );

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_PUSH_PC:  begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = spb_q - AW'(4); mem_wdata = retpc_q; end
      S_PUSH_FMT: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = spb_q - AW'(8); mem_wdata = fmt_q; end
      S_VEC:      begin mem_valid = 1'b1; mem_addr = vbr_q + AW'({idx_q, 2'b00}); end
      S_POP_FMT:  begin mem_valid = 1'b1; mem_addr = spb_q; end
      S_POP_PC:   begin mem_valid = 1'b1; mem_addr = spb_q + AW'(4); end
      default: ;
    endcase
  end

  assign xfer = mem_valid && mem_ready;
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      idx_q <= '0; fmt_q <= '0; retpc_q <= '0; spb_q <= '0; vbr_q <= '0;
      pc_out <= '0; sr_out <= '0; sp_out <= '0;
      sp_switch <= 1'b0; done <= 1'b0;
    end else begin
      sp_switch <= 1'b0;
      done      <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (go_exc || go_irq) begin
            idx_q   <= idx_sel;
            fmt_q   <= b_fmt;
            retpc_q <= b_ret;
            spb_q   <= b_spb;
            vbr_q   <= vbr_in;
            sr_out  <= b_sr;
            st      <= S_SWITCH;
          end else if (go_ret) begin
            spb_q <= sp_in;
            st    <= S_POP_FMT;
          end
        end
        S_SWITCH: begin
          sp_switch <= 1'b1;
          st        <= S_PUSH_PC;
        end
        S_PUSH_PC:  if (xfer) st <= S_PUSH_FMT;
        S_PUSH_FMT: if (xfer) st <= S_VEC;
        S_VEC: if (xfer) begin
          pc_out <= mem_rdata;
          sp_out <= spb_q - AW'(8);
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        S_POP_FMT: if (xfer) begin
          fmt_q  <= mem_rdata;
          sr_out <= mem_rdata[15:0];
          st     <= S_POP_PC;
        end
        S_POP_PC: if (xfer) begin
          pc_out    <= mem_rdata;
          sp_out    <= r_sp;
          sp_switch <= 1'b1;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Status word update happens one or more cycles before the switch request (R8)
  p_switch_after_sr_r8: assert property (@(posedge clk) disable iff (rst)
    sp_switch |-> (st == S_PUSH_PC) || done);

  p_entry_sup_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_PUSH_PC) |-> sr_out[SR_SUP_BIT]);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_irq_reject_r7: assert property (@(posedge clk) disable iff (rst)
    ((st == S_IDLE) && start_irq && !start_exc && !start_ret &&
     (sr_in[SR_MASK_LSB +: SR_MASK_W] >= irq_level)) |=> !busy);

  p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_valid && !busy && !done && !sp_switch);
endmodule

// File: tb/sim_exc_frame_seq.sv
`timescale 1ns/1ps
module sim_exc_frame_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_exc = 0, start_irq = 0, start_ret = 0;
  logic [7:0] exc_idx = 0, irq_vec = 0;
  logic [2:0] irq_level = 0;
  logic [31:0] pc_in = 0, sp_in = 0, vbr_in = 0;
  logic [15:0] sr_in = 0;
  logic busy, done, sp_switch, mem_valid, mem_we, mem_ready;
  logic [31:0] pc_out, sp_out, mem_addr, mem_wdata, mem_rdata;
  logic [15:0] sr_out;

  logic [31:0] mem [0:1023];
  int acc_cnt = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  exc_frame_seq u0 (
    .clk(clk), .rst(rst), .start_exc(start_exc), .start_irq(start_irq), .start_ret(start_ret),
    .exc_idx(exc_idx), .irq_level(irq_level), .irq_vec(irq_vec), .pc_in(pc_in), .sr_in(sr_in),
    .sp_in(sp_in), .vbr_in(vbr_in), .busy(busy), .done(done), .pc_out(pc_out), .sr_out(sr_out),
    .sp_out(sp_out), .sp_switch(sp_switch), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end
  end

  initial begin
    mem_ready = 1'b0;
    forever begin
      @(negedge clk);
      mem_ready = ($urandom % 4) != 0;
    end
  end

  function automatic logic [31:0] vec_val(input logic [7:0] i);
    return 32'hA000_0000 + {22'd0, i, 2'b00} * 32'd7;
  endfunction

  function automatic logic [31:0] exp_fmt(input logic [7:0] i, input logic [15:0] s, input logic [31:0] p);
    return 32'h4000_0000 | ({30'd0, p[1:0]} << 28) | ({22'd0, i, 2'b00} << 16) | {16'd0, s};
  endfunction

  function automatic logic [15:0] exp_sr(input bit hw, input logic [15:0] s, input logic [2:0] l);
    logic [15:0] r;
    r = s | 16'h2000;
    if (hw) begin r[10:8] = l; r[12] = 1'b0; end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Wait for done; returns number of sp_switch pulses and sr seen with the first one
  task automatic wait_done(output int sw_n, output logic [15:0] sw_sr, output bit busy_ok);
    int t;
    sw_n = 0; sw_sr = 0; busy_ok = 1; t = 0;
    forever begin
      if (sp_switch) begin if (sw_n == 0) sw_sr = sr_out; sw_n++; end
      if (done) break;
      if (!busy) busy_ok = 0;
      @(negedge clk);
      t++;
      if (t > 2000) begin
        chk(0, "watchdog", 0, 1);
        break;
      end
    end
  endtask

  task automatic do_entry(input bit hw, input logic [7:0] idx, input logic [31:0] pc,
                          input logic [15:0] sr, input logic [31:0] sp, input logic [2:0] lvl,
                          output logic [31:0] sp_after, output logic [31:0] ret_after);
    int a0, sw_n; logic [15:0] sw_sr; bit bok;
    logic [31:0] al, ra, f; logic [15:0] es;
    al = {sp[31:2], 2'b00};
    ra = (!hw && idx >= 8'd32 && idx <= 8'd47) ? pc + 32'd2 : pc;
    f  = exp_fmt(idx, sr, sp);
    es = exp_sr(hw, sr, lvl);
    @(negedge clk);
    a0 = acc_cnt;
    pc_in = pc; sr_in = sr; sp_in = sp; vbr_in = 32'd0;
    if (hw) begin start_irq = 1; irq_vec = idx; irq_level = lvl; exc_idx = ~idx; end
    else begin start_exc = 1; exc_idx = idx; irq_vec = ~idx; end
    @(negedge clk);
    start_irq = 0; start_exc = 0;
    wait_done(sw_n, sw_sr, bok);
    chk(bok, "R10 busy during entry", {31'd0, bok}, 1);
    chk(!busy, "R10 busy low at done", {31'd0, busy}, 0);
    chk(mem[(al - 32'd8) >> 2] == f, "R1 format word", mem[(al - 32'd8) >> 2], f);
    chk(mem[(al - 32'd4) >> 2] == ra, "R5 resume address", mem[(al - 32'd4) >> 2], ra);
    chk(sp_out == al - 32'd8, "R2 final sp", sp_out, al - 32'd8);
    chk(pc_out == vec_val(idx), "R3 handler pc", pc_out, vec_val(idx));
    chk(sr_out == es, "R4 entry sr", {16'd0, sr_out}, {16'd0, es});
    chk(acc_cnt - a0 == 3, "R9 entry transfers", acc_cnt - a0, 3);
    chk(sw_n == 1 && sw_sr == es, "R8 switch after sr", {sw_n[15:0], sw_sr}, {16'd1, es});
    @(negedge clk);
    chk(!done, "R10 done one cycle", {31'd0, done}, 0);
    sp_after = sp_out; ret_after = ra;
  endtask

  task automatic do_ret(input logic [31:0] sp, input logic [31:0] exp_pc,
                        input logic [15:0] exp_s, input logic [31:0] exp_sp);
    int a0, sw_n; logic [15:0] sw_sr; bit bok;
    @(negedge clk);
    a0 = acc_cnt;
    sp_in = sp; start_ret = 1;
    @(negedge clk);
    start_ret = 0;
    wait_done(sw_n, sw_sr, bok);
    chk(bok, "R10 busy during return", {31'd0, bok}, 1);
    chk(pc_out == exp_pc, "R6 restored pc", pc_out, exp_pc);
    chk(sr_out == exp_s, "R6 restored sr", {16'd0, sr_out}, {16'd0, exp_s});
    chk(sp_out == exp_sp, "R6 restored sp", sp_out, exp_sp);
    chk(acc_cnt - a0 == 2, "R9 return transfers", acc_cnt - a0, 2);
    chk(sw_n == 1 && sw_sr == exp_s, "R8 switch on return", {sw_n[15:0], sw_sr}, {16'd1, exp_s});
    @(negedge clk);
  endtask

  task automatic do_reject(input logic [15:0] sr, input logic [2:0] lvl);
    int a0; bit seen;
    @(negedge clk);
    a0 = acc_cnt; seen = 0;
    sr_in = sr; irq_level = lvl; irq_vec = 8'd64; start_irq = 1;
    @(negedge clk);
    start_irq = 0;
    for (int k = 0; k < 6; k++) begin
      if (busy || done || mem_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen && acc_cnt == a0, "R7 masked request ignored", {31'd0, seen}, 0);
  endtask

  initial begin
    logic [31:0] spa, ra;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = (i < 256) ? vec_val(i[7:0]) : 32'd0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid && !sp_switch, "R11 reset idle",
        {28'd0, busy, done, mem_valid, sp_switch}, 0);
    rst = 0;
    @(negedge clk);
    chk(!busy && !mem_valid, "R11 idle after reset", {30'd0, busy, mem_valid}, 0);

    // Directed: trap boundaries, misalignment, interrupts
    do_entry(0, 8'd32, 32'h1000, 16'h0005, 32'hC03, 3'd0, spa, ra);
    do_ret(spa, ra, 16'h0005, 32'hC03);
    do_entry(0, 8'd47, 32'h2000, 16'h0700, 32'hC42, 3'd0, spa, ra);
    do_ret(spa, ra, 16'h0700, 32'hC42);
    do_entry(0, 8'd48, 32'h3000, 16'h0000, 32'hC81, 3'd0, spa, ra);
    do_entry(0, 8'd31, 32'h3100, 16'h1000, 32'hC80, 3'd0, spa, ra);
    do_entry(1, 8'd40, 32'h4000, 16'h1300, 32'hD02, 3'd6, spa, ra);
    do_ret(spa, ra, 16'h1300, 32'hD02);
    do_reject(16'h0500, 3'd5);
    do_reject(16'h0700, 3'd7);
    do_entry(1, 8'd255, 32'h5000, 16'h0400, 32'hD40, 3'd5, spa, ra);

    // Directed return from a hand-built frame: misalignment 3, sr 0x0704
    @(negedge clk);
    mem[32'hE00 >> 2] = 32'h7000_0704;
    mem[32'hE04 >> 2] = 32'h0000_8888;
    do_ret(32'hE00, 32'h8888, 16'h0704, 32'hE0B);

    // Random round trips
    for (int n = 0; n < 60; n++) begin
      bit hw; logic [7:0] idx; logic [15:0] sr; logic [2:0] lvl; logic [31:0] sp, pc;
      hw  = ($urandom % 3) == 0;
      idx = 8'($urandom);
      sr  = 16'($urandom);
      lvl = 3'(1 + $urandom % 7);
      if (hw) sr[10:8] = 3'($urandom % lvl);
      sp  = 32'hC00 + ($urandom % 32'h3F0);
      pc  = $urandom & 32'hFFFF_FFFE;
      do_entry(hw, idx, pc, sr, sp, lvl, spa, ra);
      do_ret(spa, ra, sr, sp);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule